// File: doc/BRIEF.md
# Iterative Half-Adder Adder

This block adds two W-bit unsigned operands and a carry-in without a carry chain. After a request it registers the operands. It then passes a sum vector and a carry vector through one row of half-adders again and again, one pass per clock, until the carry vector holds no set bit. A 2:1 multiplexer in each bit slice chooses the registered operands on the first pass and the fed-back vectors on every later pass. The number of passes depends on the operands: operands with no overlapping set bits finish in one pass, and a full ripple takes W+1 passes.

A four-phase request/acknowledge pair controls the block. The requester drives the operands, raises `req` and waits for `ack`. It reads `sum` and `cout` while `ack` is high and then lowers `req`. The block drops `ack` before it accepts the next request. A carry that leaves the top bit on any pass is collected into the carry-out, so the result is the full W+1-bit total.

Top module: `iter_adder`

## Requirements
- R1: After synchronous reset, `ack`, `sum` and `cout` are all 0.
- R2: While `ack` is high, {`cout`,`sum`} equals `a` + `b` + `cin` as an unsigned W+1-bit value, using the operands sampled when the request was accepted.
- R3: The first pass computes sum bit i as a[i] XOR b[i] and carry into bit i+1 as a[i] AND b[i], with `cin` as the carry into bit 0. So when a AND b is zero and `cin` is 0, `ack` is high after the first rising edge that follows the sampling edge.
- R4: Every addition completes within W+1 passes after the sampling edge.
- R5: Each later pass computes sum bit i as the XOR and carry into bit i+1 as the AND of the previous sum and carry bits at i, with carry into bit 0 forced to 0. Operand a all ones, b zero and `cin` 1 therefore takes exactly W+1 passes.
- R6: `ack` stays high as long as `req` stays high, and it is low on the cycle after the edge that sees `req` low. A new request is accepted only while `ack` is low.
- R7: While `ack` is high, `sum` and `cout` hold steady, and changes on `a`, `b` or `cin` have no effect on them.
- R8: Operand inputs that change after the sampling edge, while the addition is in progress, do not affect the result.
- R9: A carry produced out of bit W-1 on any pass appears on `cout`, even after later passes clear the carry vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request; a rising request while idle samples the operands |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| ack | output | 1 | Result valid; high until req falls |
| sum | output | W | Sum vector |
| cout | output | 1 | Carry-out of the addition |

## Verification
On every cycle the bound checker checks the handshake rules and the holding of results while `ack` is high. It also checks the pass bound, using its own counter of the cycles since a request was accepted, and it compares the result at each rising `ack` with a total it captured at acceptance. Only the bench scenarios can show the latencies that depend on the data. These are the single pass for operands without carries and the exact W+1 passes for a full ripple. The scenarios also show that operand changes made mid-run or during acknowledge are ignored.

// File: rtl/iter_adder_pkg.sv
package iter_adder_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctrl_state_e;

    typedef struct packed {
        logic s;
        logic c;
    } ha_out_t;

    function automatic ha_out_t half_add(input logic x, input logic y);
        ha_out_t r;
        r.s = x ^ y;
        r.c = x & y;
        return r;
    endfunction

    function automatic logic pick2(input logic sel_first, input logic on_first, input logic on_later);
        return sel_first ? on_first : on_later;
    endfunction

endpackage

// File: rtl/iter_adder_slice.sv
module iter_adder_slice
    import iter_adder_pkg::*;
(
    input  logic    sel_first,
    input  logic    op_x,
    input  logic    op_y,
    input  logic    fb_s,
    input  logic    fb_c,
    output ha_out_t res
);
    logic in_x;
    logic in_y;

    always_comb begin
        in_x = pick2(sel_first, op_x, fb_s);
        in_y = pick2(sel_first, op_y, fb_c);
        res  = half_add(in_x, in_y);
    end
endmodule

// File: rtl/iter_adder_ctrl.sv
module iter_adder_ctrl
    import iter_adder_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic carry_zero,
    output logic load,
    output logic step,
    output logic first,
    output logic ack
);
    ctrl_state_e state_q;
    ctrl_state_e state_d;
    logic        first_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)        state_d = ST_RUN;
            ST_RUN:  if (carry_zero) state_d = ST_DONE;
            ST_DONE: if (!req)       state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load)      first_q <= 1'b1;
            else if (step) first_q <= 1'b0;
        end
    end

    assign load  = (state_q == ST_IDLE) && req;
    assign step  = (state_q == ST_RUN);
    assign first = first_q;
    assign ack   = (state_q == ST_DONE);
endmodule

// File: rtl/iter_adder_dp.sv
module iter_adder_dp
    import iter_adder_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         first,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         carry_zero
);
    logic [W-1:0] a_q, b_q, s_q, c_q;
    logic [W-1:0] s_nx, c_nx;
    logic         cin_q, cout_q, top_c;
    ha_out_t      ha [W];

    for (genvar i = 0; i < W; i++) begin : g_slice
        iter_adder_slice u_slice (
            .sel_first (first),
            .op_x      (a_q[i]),
            .op_y      (b_q[i]),
            .fb_s      (s_q[i]),
            .fb_c      (c_q[i]),
            .res       (ha[i])
        );
    end

    always_comb begin
        c_nx[0] = first ? cin_q : 1'b0;
        for (int i = 0; i < W; i++) begin
            s_nx[i] = ha[i].s;
        end
        for (int i = 0; i < W - 1; i++) begin
            c_nx[i+1] = ha[i].c;
        end
        top_c = ha[W-1].c;
    end

    assign carry_zero = (c_nx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            cin_q  <= 1'b0;
            s_q    <= '0;
            c_q    <= '0;
            cout_q <= 1'b0;
        end else if (load) begin
            a_q    <= a;
            b_q    <= b;
            cin_q  <= cin;
            s_q    <= '0;
            c_q    <= '0;
            cout_q <= 1'b0;
        end else if (step) begin
            s_q    <= s_nx;
            c_q    <= c_nx;
            cout_q <= cout_q | top_c;
        end
    end

    assign sum  = s_q;
    assign cout = cout_q;
endmodule

// File: rtl/iter_adder.sv
module iter_adder
    import iter_adder_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic         ack,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic load, step, first, carry_zero;

    iter_adder_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .carry_zero (carry_zero),
        .load       (load),
        .step       (step),
        .first      (first),
        .ack        (ack)
    );

    iter_adder_dp #(.W(W)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (step),
        .first      (first),
        .a          (a),
        .b          (b),
        .cin        (cin),
        .sum        (sum),
        .cout       (cout),
        .carry_zero (carry_zero)
    );
endmodule

// File: rtl/iter_adder_chk.sv
module iter_adder_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         req,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         cin,
    input logic         ack,
    input logic [W-1:0] sum,
    input logic         cout
);
    localparam int CW = $clog2(W + 3) + 1;

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            exp_q  <= '0;
        end else if (!busy_q && !ack && req) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            exp_q  <= {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        end else if (busy_q && ack) begin
            busy_q <= 1'b0;
        end else if (busy_q && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!ack && sum == '0 && !cout));

    assert_result_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> ({cout, sum} == exp_q));

    assert_pass_bound_R4: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= CW'(W + 1)));

    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && req) |=> ack);

    assert_ack_release_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && !req) |=> !ack);

    assert_result_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && req) |=> ($stable(sum) && $stable(cout)));
endmodule

bind iter_adder iter_adder_chk #(.W(W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .a    (a),
    .b    (b),
    .cin  (cin),
    .ack  (ack),
    .sum  (sum),
    .cout (cout)
);

// File: tb/tb_iter_adder.sv
`timescale 1ns/1ps
module tb_iter_adder;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic         ack;
    logic [W-1:0] sum;
    logic         cout;

    int n_chk  = 0;
    int n_fail = 0;
    int passes = 0;

    always #4 clk = ~clk;

    iter_adder #(.W(W)) dut (
        .clk(clk), .rst(rst), .req(req), .a(a), .b(b), .cin(cin),
        .ack(ack), .sum(sum), .cout(cout)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    endfunction

    // Raise req with operands, wait for ack, return passes taken
    task automatic start_wait(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci,
                              input bit scramble);
        int cnt;
        @(negedge clk);
        a = x; b = y; cin = ci; req = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (scramble) begin a = ~x; b = ~y; cin = ~ci; end
        end while (!ack && cnt < W + 20);
        passes = cnt - 1;
    endtask

    task automatic release_req(input string rq);
        req = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, rq, "ack low after req falls", 64'(ack), 64'd0);
    endtask

    task automatic t_reset();
        check(ack == 1'b0, "R1", "ack after reset", 64'(ack), 64'd0);
        check(sum == '0,   "R1", "sum after reset", 64'(sum), 64'd0);
        check(cout == 1'b0, "R1", "cout after reset", 64'(cout), 64'd0);
    endtask

    task automatic t_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci,
                         input int exp_passes, input string rq);
        logic [W:0] e;
        e = ref_add(x, y, ci);
        start_wait(x, y, ci, 1'b0);
        check(ack == 1'b1, rq, "ack raised", 64'(ack), 64'd1);
        check({cout, sum} == e, "R2", "result", 64'({cout, sum}), 64'(e));
        check(passes <= W + 1, "R4", "pass bound", 64'(passes), 64'(W + 1));
        if (exp_passes > 0)
            check(passes == exp_passes, rq, "pass count", 64'(passes), 64'(exp_passes));
        release_req("R6");
    endtask

    // R3: disjoint operands finish in one pass
    task automatic t_no_carry();
        t_add(16'hA5A0, 16'h5A0F, 1'b0, 1, "R3");
        t_add(16'h0000, 16'h0000, 1'b0, 1, "R3");
    endtask

    // R5: full ripple takes W+1 passes
    task automatic t_ripple();
        t_add({W{1'b1}}, '0, 1'b1, W + 1, "R5");
        t_add(16'h0001, 16'h0001, 1'b0, 2, "R5");
    endtask

    // R9: carry leaving the top bit reaches cout
    task automatic t_carry_out();
        t_add({W{1'b1}}, {W{1'b1}}, 1'b1, 0, "R9");
        check(1'b1, "R9", "max+max observed", 64'd0, 64'd0);
        t_add(16'h8000, 16'h8000, 1'b0, 0, "R9");
    endtask

    // R8: operands scrambled during the run are ignored
    task automatic t_mid_change();
        logic [W:0] e;
        e = ref_add(16'h1234, 16'h0FFF, 1'b1);
        start_wait(16'h1234, 16'h0FFF, 1'b1, 1'b1);
        check({cout, sum} == e, "R8", "result with moving inputs", 64'({cout, sum}), 64'(e));
        release_req("R8");
    endtask

    // R6/R7: held req keeps ack, result steady, no restart
    task automatic t_hold();
        logic [W:0] e;
        e = ref_add(16'h7777, 16'h1111, 1'b0);
        start_wait(16'h7777, 16'h1111, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            a = 16'(k * 16'h1357); b = ~a; cin = k[0];
            @(negedge clk);
            check(ack == 1'b1, "R6", "ack held", 64'(ack), 64'd1);
            check({cout, sum} == e, "R7", "result held", 64'({cout, sum}), 64'(e));
        end
        release_req("R6");
        t_add(16'h0F0F, 16'h00F1, 1'b0, 0, "R6");
    endtask

    task automatic t_sweep();
        logic [W-1:0] x, y;
        x = 16'h1D2B;
        y = 16'h9E41;
        for (int k = 0; k < 24; k++) begin
            x = (x << 3) ^ (x >> 5) ^ 16'(k * 16'h2F3);
            y = (y >> 2) ^ (y << 7) ^ 16'(k * 16'h51);
            t_add(x, y, k[1], 0, "R2");
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_carry();
        t_ripple();
        t_carry_out();
        t_mid_change();
        t_hold();
        t_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule